// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital timing and counting core of a three-and-a-half digit dual-slope analog-to-digital converter. A divide-by-four prescaler turns the input clock into a count clock. The count clock steps a fixed-length measurement cycle through three phases. In the first, the analog front end nulls its offsets. In the second, the input is integrated for a fixed time. In the third, a reference of opposite sign discharges the integrator back to zero. Each phase drives its own enable for the external analog switches, and exactly one enable is active at any time.

A single comparator bit is the only analog feedback. It is high when the integrator holds charge from a positive input. Its state at the end of integration gives the sign of the input. A change of that bit during the discharge phase marks the zero crossing. The number of count clocks spent discharging is the reading, equal to 1000 × Vin/Vref, and it is counted directly in four BCD digits. The reading, a negative-sign flag and an overrange flag are latched when discharge ends and are held for a display stage. The cycle always lasts 4000 counts, because offset nulling takes whatever discharge time the input left unused.

Top module: `dsadc_seq`

## Requirements
- R1: Phase timing advances only once every 4 input clocks (one count). The integrate enable `int_en_o` stays high for exactly 1000 counts (4000 clocks).
- R2: The phases run in the order null (`az_en_o`), integrate (`int_en_o`), discharge (`de_en_o`), then null again. After reset exactly one of the three enables is high in every cycle.
- R3: `cmp_i` is sampled on the last count of the integrate phase. `neg_o` is latched as 1 when that sample was 0 (negative input) and as 0 when it was 1.
- R4: In the discharge phase, the first count at which `cmp_i` differs from the integrate-end sample ends the phase. If n counts have passed before that count, the phase lasts n+1 counts (4(n+1) clocks) and `digits_o` is n in BCD: thousands digit in [15:12], hundreds in [11:8], tens in [7:4], units in [3:0].
- R5: If `cmp_i` has not changed by the 2000th discharge count, discharge ends on that count. `ovr_o` is then latched as 1 and `digits_o` as BCD 1999. A crossing that is detected ends the phase with `ovr_o` 0.
- R6: The null phase after a discharge of d counts lasts 3000−d counts. Every measurement cycle is therefore 4000 counts (16,000 clocks), for any input.
- R7: `digits_o`, `neg_o` and `ovr_o` change only on the clock edge where `de_en_o` falls. At all other times they hold their value.
- R8: A synchronous active-high `rst` makes `az_en_o` high and the other enables low, and clears `digits_o`, `neg_o` and `ovr_o`. The first null phase after reset lasts 3000 counts (12,000 clocks from the last reset edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_i | input | 1 | Integrator comparator, 1 = positive charge |
| az_en_o | output | 1 | Offset-null switch enable |
| int_en_o | output | 1 | Signal-integrate switch enable |
| de_en_o | output | 1 | Reference-discharge switch enable |
| digits_o | output | 16 | Latched BCD reading, four digits |
| neg_o | output | 1 | Latched negative-input flag |
| ovr_o | output | 1 | Latched overrange flag |

## Verification
The embedded properties assume that `rst` is held high from time zero until the first edges have passed. They also assume that the default full scale keeps the thousands digit at 0 or 1, which makes the latched overrange reading BCD 1999. The stimulus follows a simple comparator model. It sets `cmp_i` to the chosen sign when integration begins and holds it until the planned discharge count. It then inverts the bit midway between two counts, so every sample falls clear of a transition. For overrange it never inverts the bit. The planned counts are directed corners (0, 999, 1000, 1999, beyond full scale) and seeded random values up to 2100.

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
  parameter int PRESCALE     = 4,
  parameter int INT_COUNTS   = 1000,
  parameter int FULL_COUNTS  = 2000,
  parameter int CYCLE_COUNTS = 4000,
  parameter int DIGITS       = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmp_i,
  output logic                  az_en_o,
  output logic                  int_en_o,
  output logic                  de_en_o,
  output logic [4*DIGITS-1:0]   digits_o,
  output logic                  neg_o,
  output logic                  ovr_o
);
  localparam int PW      = $clog2(PRESCALE);
  localparam int CW      = $clog2(CYCLE_COUNTS);
  localparam int BW      = 4 * DIGITS;
  localparam int DE_LAST = INT_COUNTS + FULL_COUNTS - 1;

  function automatic logic [BW-1:0] to_bcd(input int v);
    logic [BW-1:0] r;
    int x;
    x = v;
    r = '0;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  localparam logic [BW-1:0] OVR_READING = to_bcd(FULL_COUNTS - 1);

  typedef enum logic [1:0] {PH_AZ, PH_INT, PH_DE} phase_t;

  phase_t          ph;
  logic [PW-1:0]   pre;
  logic [CW-1:0]   cyc;
  logic            sgn;
  logic [BW-1:0]   cnt, cnt_inc;
  logic [DIGITS:0] cy;

  wire tick     = pre == PW'(PRESCALE - 1);
  wire last_cyc = cyc == CW'(CYCLE_COUNTS - 1);
  wire last_int = cyc == CW'(INT_COUNTS - 1);
  wire de_force = cyc == CW'(DE_LAST);
  wire trip     = cmp_i != sgn;

  assign cy[0] = 1'b1;
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    wire nine = cnt[4*g +: 4] == 4'd9;
    assign cnt_inc[4*g +: 4] = !cy[g] ? cnt[4*g +: 4] :
                               nine   ? 4'd0 : cnt[4*g +: 4] + 4'd1;
    assign cy[g+1] = cy[g] & nine;

    a_r4_digit_range: assert property (@(posedge clk) disable iff (rst)
      digits_o[4*g +: 4] <= 4'd9);
  end

  assign az_en_o  = ph == PH_AZ;
  assign int_en_o = ph == PH_INT;
  assign de_en_o  = ph == PH_DE;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre      <= '0;
      cyc      <= CW'(INT_COUNTS);
      ph       <= PH_AZ;
      sgn      <= 1'b0;
      cnt      <= '0;
      digits_o <= '0;
      neg_o    <= 1'b0;
      ovr_o    <= 1'b0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) begin
        cyc <= last_cyc ? '0 : cyc + 1'b1;
        case (ph)
          PH_AZ: if (last_cyc) ph <= PH_INT;
          PH_INT: if (last_int) begin
            ph  <= PH_DE;
            sgn <= cmp_i;
            cnt <= '0;
          end
          PH_DE: if (trip || de_force) begin
            ph       <= PH_AZ;
            digits_o <= cnt;
            neg_o    <= ~sgn;
            ovr_o    <= ~trip;
          end else begin
            cnt <= cnt_inc;
          end
          default: ph <= PH_AZ;
        endcase
      end
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot({az_en_o, int_en_o, de_en_o}));
  a_r2_int_after_az: assert property (@(posedge clk) disable iff (rst)
    $rose(int_en_o) |-> $past(az_en_o));
  a_r2_de_after_int: assert property (@(posedge clk) disable iff (rst)
    $rose(de_en_o) |-> $past(int_en_o));
  a_r2_az_after_de: assert property (@(posedge clk) disable iff (rst)
    $rose(az_en_o) |-> $past(de_en_o));
  a_r1_phase_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(ph));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !$fell(de_en_o) |-> $stable({digits_o, neg_o, ovr_o}));
  a_r5_ovr_reading: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> digits_o == OVR_READING);
endmodule

// File: tb/dsadc_seq_bench.sv
module dsadc_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp = 1'b0;
  logic az_en, int_en, de_en, neg, ovr;
  logic [15:0] digits;

  dsadc_seq u_dsadc_seq (
    .clk(clk), .rst(rst), .cmp_i(cmp),
    .az_en_o(az_en), .int_en_o(int_en), .de_en_o(de_en),
    .digits_o(digits), .neg_o(neg), .ovr_o(ovr)
  );

  always #10 clk = ~clk;

  int unsigned edges = 0;
  always @(posedge clk) edges++;

  int checks = 0;
  int errors = 0;
  int oh_bad = 0;

  always @(negedge clk)
    if (!rst && ({az_en, int_en, de_en} != 3'b001) && ({az_en, int_en, de_en} != 3'b010)
        && ({az_en, int_en, de_en} != 3'b100))
      oh_bad++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] bcd4(input int v);
    logic [15:0] r;
    int x;
    x = v;
    for (int i = 0; i < 4; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic int de_counts(input int n);
    return (n >= 1999) ? 2000 : n + 1;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected 0", edges);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned t_rel, t_int, t_de, t_fall;
    int plan_n [9];
    bit plan_s [9];
    logic [15:0] exp_d;
    logic exp_neg, exp_ovr;
    void'($urandom(32'd4711));
    plan_n[0] = 5;    plan_s[0] = 1'b1;
    plan_n[1] = 0;    plan_s[1] = 1'b0;
    plan_n[2] = 1999; plan_s[2] = 1'b1;
    plan_n[3] = 2500; plan_s[3] = 1'b0;
    plan_n[4] = 999;  plan_s[4] = 1'b1;
    plan_n[5] = 1000; plan_s[5] = 1'b0;
    for (int k = 6; k < 9; k++) begin
      plan_n[k] = int'($urandom_range(2100, 0));
      plan_s[k] = 1'($urandom_range(1, 0));
    end

    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(az_en && !int_en && !de_en, "R8 enables in reset", {az_en, int_en, de_en}, 3'b100);
    chk(digits == 16'h0 && !neg && !ovr, "R8 outputs in reset", {digits, neg, ovr}, 0);
    rst = 1'b0;
    t_rel = edges;

    do @(negedge clk); while (int_en !== 1'b1);
    chk(edges - t_rel == 12000, "R8 first null length", edges - t_rel, 12000);
    chk(digits == 16'h0 && !neg && !ovr, "R8 outputs held zero", {digits, neg, ovr}, 0);

    for (int k = 0; k < 9; k++) begin
      int n;
      bit s;
      n = plan_n[k];
      s = plan_s[k];
      cmp = s;
      t_int = edges;
      do @(negedge clk); while (de_en !== 1'b1);
      chk(edges - t_int == 4000, "R1 integrate length", edges - t_int, 4000);
      t_de = edges;
      if (n < 2000) begin
        repeat (4 * n + 2) @(posedge clk);
        @(negedge clk);
        cmp = ~s;
      end
      do @(negedge clk); while (de_en !== 1'b0);
      t_fall = edges;
      chk(t_fall - t_de == 4 * de_counts(n), "R4 discharge length", t_fall - t_de,
          4 * de_counts(n));
      exp_d   = (n >= 2000) ? 16'h1999 : bcd4(n);
      exp_neg = ~s;
      exp_ovr = (n >= 2000);
      chk(digits == exp_d, "R4 BCD reading", digits, exp_d);
      chk(neg == exp_neg, "R3 polarity flag", neg, exp_neg);
      chk(ovr == exp_ovr, "R5 overrange flag", ovr, exp_ovr);
      chk(az_en === 1'b1, "R2 null follows discharge", az_en, 1);
      do @(negedge clk); while (int_en !== 1'b1);
      chk(edges - t_fall == 4 * (3000 - de_counts(n)), "R6 null length", edges - t_fall,
          4 * (3000 - de_counts(n)));
      chk(edges - t_int == 16000, "R6 cycle length", edges - t_int, 16000);
      chk(digits == exp_d && neg == exp_neg && ovr == exp_ovr, "R7 outputs held",
          {digits, neg, ovr}, {exp_d, exp_neg, exp_ovr});
    end

    chk(oh_bad == 0, "R2 one-hot enables", oh_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule